// File: doc/BRIEF.md
# Serial Keyboard Byte Receiver (Inverted Framing)

This block takes the serial wire from a keyboard and turns each received frame into one byte. The byte is normally the ASCII code of the key that was pressed. A frame holds ten bits in this order: a start bit, eight data bits and a stop bit. The polarity is the reverse of a common UART. The line rests at 0, the start bit is 1 and the stop bit is 0. Data bits arrive most significant first.

The line is oversampled from the system clock. A programmable divisor sets the rate of a sampling tick, and each bit lasts sixteen ticks. The input goes through a two-flop synchronizer. After that, a rising edge starts a frame, and the start bit is confirmed half a bit later. Each data bit and the stop bit are taken at their middle tick.

A frame with a good stop bit loads a single holding register and pulses a valid strobe for one clock. A frame with a bad stop bit pulses an error strobe and drops the byte.

Top module: `kbd_rx_inv`

## Requirements
- R1: While reset is asserted and after it is released, `rx_byte` is 0x00 and `rx_valid` and `frame_err` are low.
- R2: A frame made of start 1, then eight data bits with the most significant bit first, then stop 0 sets `rx_byte` to that byte. For example, 0x61 is sent on the wire as 1,0,1,1,0,0,0,0,1,0.
- R3: Each good frame raises `rx_valid` for exactly one clock cycle.
- R4: A frame whose stop bit reads 1 raises `frame_err` for exactly one clock cycle. It raises no `rx_valid` and leaves `rx_byte` unchanged.
- R5: A high pulse on the line that ends before the middle of the start bit starts no frame. It produces no `rx_valid` and no `frame_err`.
- R6: A line held at 0 produces no `rx_valid` and no `frame_err`.
- R7: One bit period is 16 × (`baud_div` + 1) clock cycles, and the receiver decodes correctly at any divisor value.
- R8: A frame whose start bit follows the previous stop bit with no idle gap is received correctly.
- R9: `rx_valid` and `frame_err` are never high in the same cycle.
- R10: `rx_byte` changes only in a cycle where `rx_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | DIV_W | Sampling tick every baud_div+1 clocks |
| rx_line | input | 1 | Serial line from the keyboard, idle 0 |
| rx_byte | output | 8 | Holding register with the last good byte |
| rx_valid | output | 1 | One-cycle strobe: new byte in rx_byte |
| frame_err | output | 1 | One-cycle strobe: stop bit read as 1 |

## Verification
The properties assume that `baud_div` does not change while a frame is being received. They also assume that the line changes only at bit boundaries of the programmed rate, apart from deliberate short glitches. The bench changes the divisor only when the line is idle. It drives every bit for a whole number of bit periods computed from that divisor. Its only sub-bit pulse is the glitch test, which is kept well short of half a bit.

// File: rtl/kbd_rx_inv.sv
module kbd_rx_inv #(
  parameter int DIV_W = 12,
  parameter int OSR   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             rx_line,
  output logic [7:0]       rx_byte,
  output logic             rx_valid,
  output logic             frame_err
);
  localparam int SW = $clog2(OSR);
  localparam logic [SW-1:0] MID  = SW'(OSR/2 - 1);
  localparam logic [SW-1:0] LAST = SW'(OSR - 1);

  typedef enum logic [1:0] {S_IDLE, S_START, S_DATA, S_STOP} st_t;

  st_t             state;
  logic [1:0]      sync;
  logic            prev;
  logic [DIV_W-1:0] pcnt;
  logic [SW-1:0]   scnt;
  logic [2:0]      bcnt;
  logic [7:0]      shreg;

  wire line = sync[1];
  wire rise = line & ~prev;
  wire tick = (pcnt == baud_div);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync <= '0;
      prev <= 1'b0;
    end else begin
      sync <= {sync[0], rx_line};
      prev <= line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || state == S_IDLE || tick) pcnt <= '0;
    else                                  pcnt <= pcnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      scnt      <= '0;
      bcnt      <= '0;
      shreg     <= '0;
      rx_byte   <= '0;
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      rx_valid  <= 1'b0;
      frame_err <= 1'b0;
      case (state)
        S_IDLE: if (rise) begin
          state <= S_START;
          scnt  <= '0;
        end
        S_START: if (tick) begin
          if (scnt == MID) begin
            scnt <= '0;
            bcnt <= '0;
            state <= line ? S_DATA : S_IDLE;
          end else scnt <= scnt + 1'b1;
        end
        S_DATA: if (tick) begin
          if (scnt == LAST) begin
            scnt  <= '0;
            shreg <= {shreg[6:0], line};
            if (bcnt == 3'd7) state <= S_STOP;
            else              bcnt  <= bcnt + 1'b1;
          end else scnt <= scnt + 1'b1;
        end
        S_STOP: if (tick) begin
          if (scnt == LAST) begin
            scnt  <= '0;
            state <= S_IDLE;
            if (!line) begin
              rx_byte  <= shreg;
              rx_valid <= 1'b1;
            end else frame_err <= 1'b1;
          end else scnt <= scnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/kbd_rx_inv_chk.sv
module kbd_rx_inv_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] rx_byte,
  input logic       rx_valid,
  input logic       frame_err
);
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |=> !rx_valid); // R3
  AST_ERR_ONE_CYCLE:   assert property (@(posedge clk) disable iff (!rst_n) frame_err |=> !frame_err); // R4
  AST_STROBES_EXCL:    assert property (@(posedge clk) disable iff (!rst_n) !(rx_valid && frame_err)); // R9
  AST_BYTE_HOLD:       assert property (@(posedge clk) disable iff (!rst_n) !$stable(rx_byte) |-> rx_valid); // R10
  AST_ERR_NO_LOAD:     assert property (@(posedge clk) disable iff (!rst_n) frame_err |-> $stable(rx_byte)); // R4
endmodule

bind kbd_rx_inv kbd_rx_inv_chk u_chk (.*);

// File: tb/sim_kbd_rx_inv.sv
module sim_kbd_rx_inv;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] baud_div = 12'd3;
  logic        rx_line = 1'b0;
  logic [7:0]  rx_byte;
  logic        rx_valid, frame_err;

  int n_chk = 0, n_bad = 0;
  int n_val = 0, n_err = 0, n_both = 0, run = 0, max_run = 0;
  logic [7:0] got_last = '0, got_prev = '0;
  bit done = 0;

  always #10 clk = ~clk;

  kbd_rx_inv u0 (.clk(clk), .rst_n(rst_n), .baud_div(baud_div), .rx_line(rx_line),
                 .rx_byte(rx_byte), .rx_valid(rx_valid), .frame_err(frame_err));

  always @(negedge clk) if (rst_n) begin
    if (rx_valid) begin n_val++; got_prev = got_last; got_last = rx_byte; run++; end
    else run = 0;
    if (run > max_run) max_run = run;
    if (frame_err) n_err++;
    if (rx_valid && frame_err) n_both++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bit_hold(input logic v, input int bits);
    rx_line = v;
    repeat (bits * 16 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] b, input logic stopv, input bit gap);
    bit_hold(1'b1, 1);
    for (int i = 7; i >= 0; i--) bit_hold(b[i], 1);
    bit_hold(stopv, 1);
    if (gap) bit_hold(1'b0, 2);
  endtask

  task automatic t_reset;
    chk(rx_byte == 8'h00, "R1 byte", rx_byte, 0);
    chk(!rx_valid && !frame_err, "R1 strobes", {rx_valid, frame_err}, 0);
  endtask

  task automatic t_idle;
    int v0 = n_val, e0 = n_err;
    rx_line = 1'b0;
    repeat (3000) @(negedge clk);
    chk(n_val == v0 && n_err == e0, "R6 idle quiet", n_val + n_err - v0 - e0, 0);
  endtask

  task automatic t_good(input logic [7:0] b, input string req);
    int v0 = n_val, e0 = n_err;
    send(b, 1'b0, 1);
    chk(n_val == v0 + 1 && n_err == e0, {req, " one valid"}, n_val - v0, 1);
    chk(got_last == b, {req, " byte"}, got_last, b);
  endtask

  task automatic t_ferr;
    int v0 = n_val, e0 = n_err;
    logic [7:0] keep = rx_byte;
    send(8'h3C, 1'b1, 1);
    chk(n_err == e0 + 1, "R4 error pulse", n_err - e0, 1);
    chk(n_val == v0, "R4 no valid", n_val - v0, 0);
    chk(rx_byte == keep, "R4 R10 byte held", rx_byte, keep);
  endtask

  task automatic t_glitch;
    int v0 = n_val, e0 = n_err;
    rx_line = 1'b1;
    repeat (4 * (int'(baud_div) + 1)) @(negedge clk);
    bit_hold(1'b0, 3);
    chk(n_val == v0 && n_err == e0, "R5 glitch ignored", n_val + n_err - v0 - e0, 0);
  endtask

  task automatic t_b2b;
    int v0 = n_val;
    send(8'h5A, 1'b0, 0);
    send(8'hC3, 1'b0, 1);
    chk(n_val == v0 + 2, "R8 two frames", n_val - v0, 2);
    chk(got_prev == 8'h5A && got_last == 8'hC3, "R8 bytes", {got_prev, got_last}, 16'h5AC3);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_idle();
    t_good(8'h61, "R2 0x61");
    chk(max_run == 1, "R3 valid width", max_run, 1);
    t_good(8'h80, "R2 msb");
    t_good(8'h01, "R2 lsb");
    t_good(8'hA5, "R2 0xA5");
    t_good(8'hFF, "R2 0xFF");
    t_good(8'h00, "R2 0x00");
    t_ferr();
    t_glitch();
    t_b2b();
    baud_div = 12'd0;
    t_good(8'h96, "R7 div0");
    baud_div = 12'd9;
    t_good(8'h4B, "R7 div9");
    t_glitch();
    chk(n_both == 0, "R9 exclusive", n_both, 0);
    chk(max_run == 1, "R3 valid width all", max_run, 1);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule